// File: doc/BRIEF.md
# Instruction Cycle Clock Divider

This block turns the main system clock into a one-cycle-wide instruction-cycle enable. The core advances only in cycles where the enable is high. A 4-bit select code picks one of nine division ratios, each three times a power of two, from 3 up to 768 main-clock periods. The slowest ratios let the core run at very low current. At a 10 MHz main clock the instruction cycle runs from 300 ns up to 76.8 us. The block does not generate or gate any clock. Its only product is the enable, in the main clock domain.

The ratio is built from two stages. A divide-by-three prescaler is written as a three-state machine (`PRE_PH0` → `PRE_PH1` → `PRE_PH2` → `PRE_PH0`). Its `PRE_PH2` state marks the end of each group of three clocks. A binary stage counts these prescaler ticks up to 2^code. A pulse is emitted when the last tick of the last group arrives.

A select strobe stores a new code in a pending register. A second state machine tracks whether a change is waiting:
- `SEL_STEADY` → `SEL_PENDING` on a valid strobe.
- `SEL_PENDING` → `SEL_STEADY` at a cycle boundary with no new strobe.
- `SEL_PENDING` stays in `SEL_PENDING` when a valid strobe arrives in that state.

The pending code becomes active only at the boundary where the enable is emitted. Because of this, the period in progress always completes at its old length.

Top module: `icd_cycle_div`

## Requirements
- R1: While reset is asserted, `cyc_en` is 0 and `sel_active` is 0 (ratio 3).
- R2: After reset is released, the first `cyc_en` pulse is high in the cycle that follows the third rising clock edge.
- R3: With an active code k in 0..8, successive `cyc_en` pulses are exactly 3·2^k clocks apart.
- R4: `cyc_en` is never high in two consecutive cycles.
- R5: A code loaded with `sel_load` = 1 does not shorten or lengthen the period in progress. `sel_active` changes to the new code in the same cycle that `cyc_en` is high. The following period uses the new ratio.
- R6: A strobe carrying a code from 9 to 15 is ignored. The active and pending setting stay as they were.
- R7: When several valid codes are loaded within one period, the last one takes effect at the next pulse.
- R8: Changes on `sel_in` while `sel_load` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_in | input | 4 | Requested ratio code; ratio = 3·2^code, valid codes 0..8 |
| sel_load | input | 1 | Strobe: capture `sel_in` at this rising edge |
| cyc_en | output | 1 | One-clock instruction-cycle enable pulse |
| sel_active | output | 4 | Code currently governing the period length |

## Verification
The bench measures the gap between every pair of pulses. It checks each gap together with the `sel_active` value shown at that pulse.

A design that applied a change at once, instead of at the boundary, would show a short or long transition period. It would also move `sel_active` in a cycle with no pulse.

The bench also covers several other cases:
- Out-of-range codes are sent; a design that accepted them would show a period that is wrong or wraps.
- Two valid codes are loaded in one period; a design that kept the first one would be caught.
- `sel_in` moves without a strobe; a design that captured it would be caught.
- A reset is applied in the middle of a slow setting. Any state left over from the old setting would show up as a wrong first-pulse delay of other than 3 clocks, or as a non-zero `sel_active`.

// File: rtl/icd_pkg.sv
package icd_pkg;

    // Phases of the divide-by-three prescaler
    typedef enum logic [1:0] {
        PRE_PH0 = 2'd0,
        PRE_PH1 = 2'd1,
        PRE_PH2 = 2'd2
    } pre_state_e;

    // Whether a ratio change is waiting for the next boundary
    typedef enum logic {
        SEL_STEADY  = 1'b0,
        SEL_PENDING = 1'b1
    } sel_state_e;

endpackage

// File: rtl/icd_prescale3.sv
module icd_prescale3
    import icd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    pre_state_e state_q;
    pre_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PRE_PH0;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: a plain ring of three phases
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PRE_PH0: state_d = PRE_PH1;
            PRE_PH1: state_d = PRE_PH2;
            PRE_PH2: state_d = PRE_PH0;
            default: state_d = PRE_PH0;
        endcase
    end

    // Output: the last phase closes one group of three clocks
    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            PRE_PH0: tick = 1'b0;
            PRE_PH1: tick = 1'b0;
            PRE_PH2: tick = 1'b1;
            default: tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/icd_binstage.sv
module icd_binstage #(
    parameter int SEL_W = 4,
    parameter int BIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wrap,
    input  logic [SEL_W-1:0] sel,
    output logic             last
);

    logic [BIN_W-1:0] cnt_q;
    logic [BIN_W-1:0] limit;

    // Terminal count is 2^sel - 1: bit i is set when sel exceeds i
    for (genvar gi = 0; gi < BIN_W; gi++) begin : g_limit
        assign limit[gi] = (32'(sel) > gi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == limit);

endmodule

// File: rtl/icd_selctrl.sv
module icd_selctrl
    import icd_pkg::*;
#(
    parameter int SEL_W    = 4,
    parameter int MAX_CODE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] code,
    input  logic             boundary,
    output logic [SEL_W-1:0] active
);

    sel_state_e       state_q;
    sel_state_e       state_d;
    logic [SEL_W-1:0] pend_q;
    logic [SEL_W-1:0] act_q;
    logic             code_ok;
    logic             take;

    assign code_ok = (code <= SEL_W'(MAX_CODE));
    assign take    = load && code_ok;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_STEADY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_STEADY: begin
                if (take) state_d = SEL_PENDING;
            end
            SEL_PENDING: begin
                if (boundary && !take) state_d = SEL_STEADY;
            end
            default: state_d = SEL_STEADY;
        endcase
    end

    // Output registers: pending capture and boundary-aligned apply
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (take) pend_q <= code;
            unique case (state_q)
                SEL_STEADY:  act_q <= act_q;
                SEL_PENDING: if (boundary) act_q <= pend_q;
                default:     act_q <= act_q;
            endcase
        end
    end

    assign active = act_q;

endmodule

// File: rtl/icd_cycle_div.sv
module icd_cycle_div #(
    parameter int SEL_W        = 4,
    parameter int NUM_SETTINGS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             sel_load,
    output logic             cyc_en,
    output logic [SEL_W-1:0] sel_active
);

    localparam int MAX_CODE = NUM_SETTINGS - 1;
    localparam int BIN_W    = (MAX_CODE > 0) ? MAX_CODE : 1;

    logic             pre_tick;
    logic             bin_last;
    logic             boundary;
    logic             en_q;
    logic [SEL_W-1:0] act;

    icd_prescale3 u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (pre_tick)
    );

    assign boundary = pre_tick && bin_last;

    icd_binstage #(
        .SEL_W (SEL_W),
        .BIN_W (BIN_W)
    ) u_bin (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (pre_tick),
        .wrap  (boundary),
        .sel   (act),
        .last  (bin_last)
    );

    icd_selctrl #(
        .SEL_W    (SEL_W),
        .MAX_CODE (MAX_CODE)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sel_load),
        .code     (sel_in),
        .boundary (boundary),
        .active   (act)
    );

    // Registered enable: high in the cycle after the closing edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= boundary;
        end
    end

    assign cyc_en     = en_q;
    assign sel_active = act;

endmodule

// File: rtl/icd_cycle_div_chk.sv
module icd_cycle_div_chk #(
    parameter int SEL_W        = 4,
    parameter int NUM_SETTINGS = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_en,
    input logic [SEL_W-1:0] sel_active
);

    localparam int MAX_CODE = NUM_SETTINGS - 1;
    localparam int GAP_W    = MAX_CODE + 4;

    logic [GAP_W-1:0] gap_q;
    logic [SEL_W-1:0] prev_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q      <= '0;
            prev_act_q <= '0;
        end else begin
            gap_q      <= cyc_en ? GAP_W'(1) : gap_q + 1'b1;
            prev_act_q <= sel_active;
        end
    end

    // R4: enable is a single-cycle pulse
    a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en |=> !cyc_en);

    // R5: the active code moves only together with a pulse
    a_r5_change_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |-> $stable(sel_active));

    // R6: the active code never leaves the legal range
    a_r6_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        sel_active <= SEL_W'(MAX_CODE));

    // R3 and R2: each period ends after 3 * 2^code clocks of the code that governed it
    a_r3_period: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_en |-> (gap_q == (GAP_W'(3) << prev_act_q)));

endmodule

bind icd_cycle_div icd_cycle_div_chk #(
    .SEL_W        (SEL_W),
    .NUM_SETTINGS (NUM_SETTINGS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_en     (cyc_en),
    .sel_active (sel_active)
);

// File: tb/icd_cycle_div_tb.sv
module icd_cycle_div_tb;

    localparam int CLK_P   = 10;
    localparam int WATCHDOG = 200000;

    typedef struct {
        int gap;
        int act;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel_in = 4'd0;
    logic       sel_load = 1'b0;
    logic       cyc_en;
    logic [3:0] sel_active;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t exp_q[$];
    int   gap_code = 0;
    int   exp_pend = 0;
    int   gap = 0;
    bit   prev_en = 1'b0;
    bit   done = 1'b0;
    event pulse_ev;

    icd_cycle_div u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_in     (sel_in),
        .sel_load   (sel_load),
        .cyc_en     (cyc_en),
        .sel_active (sel_active)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: samples a quarter period after each rising edge
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (!rst_n) begin
            gap = 0;
            prev_en = 1'b0;
            check(cyc_en == 1'b0, "R1 cyc_en in reset", int'(cyc_en), 0);
            check(sel_active == 4'd0, "R1 sel_active in reset", int'(sel_active), 0);
        end else begin
            gap++;
            if (cyc_en) begin
                exp_t e;
                check(!prev_en, "R4 back-to-back enable", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected pulse", gap, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(gap == e.gap, "R2/R3/R5 pulse gap", gap, e.gap);
                    check(int'(sel_active) == e.act, "R5/R6/R7 sel_active at pulse",
                          int'(sel_active), e.act);
                end
                gap = 0;
                -> pulse_ev;
            end
            prev_en = cyc_en;
        end
    end

    // Driver: queue the expected pulses, then wait for them
    task automatic run_pulses(int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{gap: 3 << gap_code, act: exp_pend});
            gap_code = exp_pend;
        end
        for (int i = 0; i < n; i++) begin
            @(pulse_ev);
        end
    endtask

    // One strobe; sel_in is then scrambled with no strobe (R8)
    task automatic load(int code);
        @(negedge clk);
        sel_in   = 4'(code);
        sel_load = 1'b1;
        if (code <= 8) exp_pend = code;
        @(negedge clk);
        sel_load = 1'b0;
        sel_in   = 4'(code ^ 4'b1011);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sel_load = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.delete();
        gap_code = 0;
        exp_pend = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);        // R1 checked by monitor
        rst_n = 1'b1;
        run_pulses(4);                     // R2 first pulse, R3 ratio 3
        load(1);  run_pulses(3);           // R5 boundary change, R3 ratio 6
        load(3);  run_pulses(3);           // R3 ratio 24
        load(8);  run_pulses(2);           // R3 ratio 768
        load(12); run_pulses(2);           // R6 code out of range ignored
        load(2);  run_pulses(2);           // R5 from slowest to ratio 12
        load(5);  load(7); run_pulses(3);  // R7 last valid load wins
        load(4);  load(15); run_pulses(2); // R6 invalid after valid
        @(negedge clk); sel_in = 4'd0;     // R8 no strobe
        repeat (5) @(negedge clk); sel_in = 4'd6;
        run_pulses(2);
        load(0);  run_pulses(3);           // R3 back to fastest
        load(6);  run_pulses(2);
        do_reset();                        // R1 mid-run reset
        run_pulses(3);                     // R2 first pulse again
        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            finish_up();
        end
    end

endmodule